// File: doc/BRIEF.md
# PMIC Command Channel

This block is one software-driven access channel that connects a 32-bit register bus to the master of a serial power-management bus. Software first loads the write-data register when the access is a write. It then writes a command word, which carries the access type, direction, target slave, byte count and register address. The channel turns that word into one request on a valid/ready back-end port.

A write is finished once the back end accepts the request. A read waits for a one-cycle response, stores the returned bytes and keeps them visible. The channel then stays in a hold state until software acknowledges with a write to the valid-clear register. A status word reports the state as a 3-bit code and also carries a sticky error flag, which is set when a command arrives while the channel is busy.

Top module: `pmic_cmd_chan`

## Requirements
- R1: After reset the status word reads 0, the command, write-data and read-data registers read 0, and `req_valid` is low.
- R2: Register byte offsets are command 0x00, write data 0x04, read data 0x14, valid-clear 0x24 and status 0x28. Command and write data read back their stored values, and any other offset reads 0.
- R3: A command write while idle moves the state code to 1 and raises `req_valid`. The request fields come from the command word: type from bits [31:30], write flag from bit 29 (1 = write), slave ID from [27:24], byte count minus one from [17:16] and address from [15:0]. `req_wdata` equals the write-data register.
- R4: While `req_valid` is high and `req_ready` is low, the request and all of its fields hold steady.
- R5: When a read request is accepted, the state code becomes 2. A `rsp_valid` pulse in state 2 captures the response and moves the state code to 6.
- R6: The captured read data keeps only the low (count+1) bytes of the response, little-endian, and the higher bytes read as 0.
- R7: In state 6 the channel stays there until software writes valid-clear with bit 0 set, which returns it to idle (code 0). A valid-clear write with bit 0 clear has no effect.
- R8: When a write request is accepted, the channel returns directly to idle and the read-data register is left unchanged.
- R9: A command write while the state is not idle is ignored and sets status bit 0, which then stays set until reset. A write-data write while the state is not idle is also ignored.
- R10: A `rsp_valid` pulse outside state 2 has no effect on the state or on the read data.
- R11: Status layout: bit 0 is the error flag, bits [3:1] hold the state code (0 idle, 1 request issued, 2 waiting for response, 6 waiting for valid-clear), and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| req_valid | output | 1 | Back-end request valid |
| req_ready | input | 1 | Back-end request accepted |
| req_type | output | 2 | Access type: 0 zero-register write, 1 register, 2 extended, 3 long extended |
| req_write | output | 1 | 1 = write, 0 = read |
| req_sid | output | 4 | Slave ID |
| req_len | output | 2 | Byte count minus one |
| req_addr | output | 16 | Target register address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | One-cycle read response strobe |
| rsp_rdata | input | 32 | Read response data |

## Verification
A wrong state code shows up in the status word in the cycle after the edge that should have moved it, and it also shows on `req_valid`. A stuck hold state shows because the status keeps reading 6 after a valid clear. A missed capture shows as stale or unmasked bytes at offset 0x14 as soon as the state reaches 6. A command wrongly taken while busy shows at once as a new request, changed request fields, or a missing error bit.

// File: rtl/pmic_cmd_chan.sv
module pmic_cmd_chan #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [1:0]    req_type,
  output logic          req_write,
  output logic [3:0]    req_sid,
  output logic [1:0]    req_len,
  output logic [15:0]   req_addr,
  output logic [31:0]   req_wdata,
  input  logic          rsp_valid,
  input  logic [31:0]   rsp_rdata
);

  localparam logic [AW-1:0] OFF_CMD   = AW'(6'h00);
  localparam logic [AW-1:0] OFF_WDATA = AW'(6'h04);
  localparam logic [AW-1:0] OFF_RDATA = AW'(6'h14);
  localparam logic [AW-1:0] OFF_CLR   = AW'(6'h24);
  localparam logic [AW-1:0] OFF_STAT  = AW'(6'h28);

  localparam logic [2:0] ST_IDLE  = 3'd0;
  localparam logic [2:0] ST_ISSUE = 3'd1;
  localparam logic [2:0] ST_WAIT  = 3'd2;
  localparam logic [2:0] ST_HOLD  = 3'd6;

  logic [2:0]  state;
  logic        err_q;
  logic [31:0] cmd_q, wdata_q, rdata_q;
  logic [31:0] rsp_masked;

  wire cmd_wr   = bus_wr && bus_addr == OFF_CMD;
  wire wdata_wr = bus_wr && bus_addr == OFF_WDATA;
  wire clr_wr   = bus_wr && bus_addr == OFF_CLR && bus_wdata[0];

  assign req_valid = state == ST_ISSUE;
  assign req_type  = cmd_q[31:30];
  assign req_write = cmd_q[29];
  assign req_sid   = cmd_q[27:24];
  assign req_len   = cmd_q[17:16];
  assign req_addr  = cmd_q[15:0];
  assign req_wdata = wdata_q;

  always_comb begin
    for (int b = 0; b < 4; b++)
      rsp_masked[8*b +: 8] = (b <= int'(cmd_q[17:16])) ? rsp_rdata[8*b +: 8] : 8'h00;
  end

  always_comb begin
    case (bus_addr)
      OFF_CMD:   bus_rdata = cmd_q;
      OFF_WDATA: bus_rdata = wdata_q;
      OFF_RDATA: bus_rdata = rdata_q;
      OFF_STAT:  bus_rdata = {28'h0, state, err_q};
      default:   bus_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      err_q   <= 1'b0;
      cmd_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (wdata_wr && state == ST_IDLE)
        wdata_q <= bus_wdata;
      if (cmd_wr) begin
        if (state == ST_IDLE) begin
          cmd_q <= bus_wdata;
          state <= ST_ISSUE;
        end else begin
          err_q <= 1'b1;
        end
      end
      case (state)
        ST_ISSUE: if (req_ready) state <= cmd_q[29] ? ST_IDLE : ST_WAIT;
        ST_WAIT:  if (rsp_valid) begin
                    rdata_q <= rsp_masked;
                    state   <= ST_HOLD;
                  end
        ST_HOLD:  if (clr_wr) state <= ST_IDLE;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/pmic_cmd_chan_chk.sv
module pmic_cmd_chan_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_type,
  input logic          req_write,
  input logic [3:0]    req_sid,
  input logic [1:0]    req_len,
  input logic [15:0]   req_addr,
  input logic [31:0]   req_wdata,
  input logic          rsp_valid,
  input logic [2:0]    state
);

  localparam logic [AW-1:0] A_CMD = AW'(6'h00);
  localparam logic [AW-1:0] A_CLR = AW'(6'h24);

  wire cmd_w = bus_wr && bus_addr == A_CMD;
  wire clr_w = bus_wr && bus_addr == A_CLR && bus_wdata[0];

  AST_CMD_START: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd0 && cmd_w |=> state == 3'd1 && req_valid); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable({req_type, req_write, req_sid, req_len, req_addr, req_wdata})); // R4
  AST_RSP_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd2 && rsp_valid |=> state == 3'd6); // R5
  AST_HOLD_UNTIL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd6 && !clr_w |=> state == 3'd6); // R7
  AST_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> state == 3'd0); // R8
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd2 && cmd_w && !rsp_valid |=> state == 3'd2); // R9
  AST_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd1 && rsp_valid && !req_ready |=> state == 3'd1); // R10

endmodule

bind pmic_cmd_chan pmic_cmd_chan_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .req_valid(req_valid), .req_ready(req_ready),
  .req_type(req_type), .req_write(req_write), .req_sid(req_sid),
  .req_len(req_len), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .state(state)
);

// File: tb/pmic_cmd_chan_bench.sv
module pmic_cmd_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [1:0]  req_type, req_len;
  logic        req_write;
  logic [3:0]  req_sid;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;

  int total = 0, bad = 0;
  logic [31:0] exp_rd;

  always #10 clk = ~clk;

  pmic_cmd_chan u_pmic_cmd_chan (.*);

  // {command, write data, back-end response}
  localparam logic [95:0] VEC [5] = '{
    {32'h4300_0012, 32'h0000_0000, 32'hAABB_CCDD},
    {32'hCF03_BEEF, 32'h0000_0000, 32'h1234_5678},
    {32'h2100_0005, 32'h0000_00A5, 32'h0000_0000},
    {32'h8701_0100, 32'h0000_0000, 32'hCAFE_F00D},
    {32'hE903_7777, 32'hDEAD_BEEF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse_ready;
    @(negedge clk); req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
  endtask

  task automatic pulse_rsp(input logic [31:0] d);
    @(negedge clk); rsp_valid = 1'b1; rsp_rdata = d;
    @(negedge clk); rsp_valid = 1'b0;
  endtask

  function automatic logic [31:0] keep_bytes(input logic [31:0] d, input logic [1:0] n);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = (b <= int'(n)) ? d[8*b +: 8] : 8'h00;
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(6'h28, v); check("R1 status", v, 0);
    rd(6'h00, v); check("R1 cmd", v, 0);
    rd(6'h04, v); check("R1 wdata", v, 0);
    rd(6'h14, v); check("R1 rdata", v, 0);
    check("R1 req_valid", {31'h0, req_valid}, 0);
    rd(6'h30, v); check("R2 unmapped", v, 0);
    exp_rd = 32'h0;

    for (int i = 0; i < 5; i++) begin
      logic [31:0] c, w, r;
      {c, w, r} = VEC[i];
      wr(6'h04, w);
      rd(6'h04, v); check("R2 wdata readback", v, w);
      wr(6'h00, c);
      rd(6'h00, v); check("R2 cmd readback", v, c);
      rd(6'h28, v); check("R3 R11 status issued", v, 32'h2);
      check("R3 fields", {req_valid, req_type, req_write, req_sid, req_len, req_addr},
            {1'b1, c[31:30], c[29], c[27:24], c[17:16], c[15:0]});
      check("R3 req_wdata", req_wdata, w);
      @(negedge clk);
      check("R4 held", {req_valid, req_addr, req_sid}, {1'b1, c[15:0], c[27:24]});
      pulse_ready;
      if (c[29]) begin
        rd(6'h28, v); check("R8 write idle", v, 32'h0);
        rd(6'h14, v); check("R8 rdata kept", v, exp_rd);
      end else begin
        rd(6'h28, v); check("R5 waiting", v, 32'h4);
        pulse_rsp(r);
        exp_rd = keep_bytes(r, c[17:16]);
        rd(6'h28, v); check("R5 R11 hold", v, 32'hC);
        rd(6'h14, v); check("R6 masked data", v, exp_rd);
        wr(6'h24, 32'h1);
        rd(6'h28, v); check("R7 cleared", v, 32'h0);
      end
    end

    // stray response while issued, then valid-clear with bit 0 low, then busy writes
    wr(6'h00, 32'h4502_0040);
    pulse_rsp(32'h5555_5555);
    rd(6'h28, v); check("R10 stray rsp state", v, 32'h2);
    rd(6'h14, v); check("R10 stray rsp data", v, exp_rd);
    pulse_ready;
    pulse_rsp(32'h0BAD_F00D);
    exp_rd = 32'h00AD_F00D;
    rd(6'h14, v); check("R6 three bytes", v, exp_rd);
    wr(6'h24, 32'h2);
    rd(6'h28, v); check("R7 no-op clear", v, 32'hC);
    wr(6'h00, 32'h4000_0001);
    rd(6'h28, v); check("R9 err set", v, 32'hD);
    check("R9 no request", {31'h0, req_valid}, 0);
    rd(6'h00, v); check("R9 cmd kept", v, 32'h4502_0040);
    wr(6'h04, 32'h7777_7777);
    rd(6'h04, v); check("R9 wdata kept", v, 32'hDEAD_BEEF);
    wr(6'h24, 32'h1);
    rd(6'h28, v); check("R9 err sticky", v, 32'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule